// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This unit adds, subtracts or negates two-digit packed decimal bytes with an incoming extend bit. Each operand byte carries one decimal digit per nibble, the upper nibble being the tens digit. The extend input is a carry-in for addition and a borrow-in for subtraction and negation. This lets a longer decimal number be processed one byte at a time, starting from the least significant byte.

The arithmetic runs as a ripple of per-digit cells. Each cell corrects its binary result back into the decimal range, and its decimal carry or borrow feeds the next digit. A flag stage forms the outgoing extend, carry and zero flags. The zero flag can only be cleared, never set. A caller that presets zero before the first byte of a multi-byte number therefore ends with zero set only if every byte came out zero. A negative flag and an overflow flag are also driven, to the result's top bit and to 0, but callers must not rely on them.

The flags and result leave through a register stage chosen by a parameter. By default the stage is present and adds one clock of latency. Without it the unit is purely combinational.

Top module: `bcd_arith_unit`

## Requirements
- R1: With `op_sel` = 2'b00 and both operands valid decimal bytes (each nibble 0 to 9), `res_bcd` is (dst + src + x_in) modulo 100, encoded with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R2: With `op_sel` = 2'b01 and valid decimal operands, `res_bcd` is (dst − src − x_in) modulo 100 in the same packed encoding.
- R3: With `op_sel` = 2'b10 or 2'b11, `res_bcd` is (0 − dst − x_in) modulo 100, and the value on `src_bcd` has no effect on any output.
- R4: `c_out` is 1 when the true decimal sum reaches 100 (add) or the true decimal difference is negative (subtract and negate), and is 0 otherwise.
- R5: `x_out` always equals `c_out`.
- R6: `z_out` is 0 when the result is nonzero and equals `z_in` when the result is zero.
- R7: When both operands are valid decimal bytes, every nibble of `res_bcd` lies in 0 to 9.
- R8: With `REG_OUT` = 1, outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` drives `res_bcd`, `x_out`, `c_out`, `z_out`, `n_out` and `v_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_sel | input | 2 | 00 add, 01 subtract, 10/11 negate |
| dst_bcd | input | 4*DIGITS (8) | Destination operand, packed decimal |
| src_bcd | input | 4*DIGITS (8) | Source operand, packed decimal (unused for negate) |
| x_in | input | 1 | Extend bit: carry-in or borrow-in |
| z_in | input | 1 | Incoming zero flag |
| res_bcd | output | 4*DIGITS (8) | Packed decimal result |
| x_out | output | 1 | Extend flag out, copy of the carry |
| c_out | output | 1 | Decimal carry or borrow out |
| z_out | output | 1 | Sticky zero flag out |
| n_out | output | 1 | Result top bit; not meaningful to callers |
| v_out | output | 1 | Tied to 0; not meaningful to callers |

## Verification
The assertions check on every cycle those properties that hold whatever the operands are:
- the extend flag mirrors the carry;
- zero is never raised when the incoming zero was clear, and is always dropped on a nonzero result;
- valid decimal operands never yield an out-of-range digit;
- negating zero with no borrow gives zero with no borrow;
- reset clears the register stage.

The exact decimal values of the result and of the carry or borrow can only be shown by the bench. It sweeps every pair of two-digit operands with both extend values under each operation and compares against integer arithmetic. It also covers the alternate negate code and confirms that a varying source byte leaves negation untouched.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

  localparam int DIGIT_W = 4;
  localparam int DIGIT_MAX = 9;
  localparam int DIGIT_FIX = 6;

  typedef enum logic [1:0] {
    BCD_OP_ADD     = 2'b00,
    BCD_OP_SUB     = 2'b01,
    BCD_OP_NEG     = 2'b10,
    BCD_OP_NEG_ALT = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic c;
    logic z;
    logic n;
    logic v;
  } bcd_flags_t;

endpackage

// File: rtl/bcd_operand_mux.sv
module bcd_operand_mux
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] dst_bcd,
  input  logic [W-1:0] src_bcd,
  output logic [W-1:0] a_opnd,
  output logic [W-1:0] b_opnd,
  output logic         sub_mode
);

  always_comb begin
    a_opnd   = dst_bcd;
    b_opnd   = src_bcd;
    sub_mode = 1'b0;
    unique case (bcd_op_e'(op_sel))
      BCD_OP_ADD: begin
        sub_mode = 1'b0;
      end
      BCD_OP_SUB: begin
        sub_mode = 1'b1;
      end
      BCD_OP_NEG, BCD_OP_NEG_ALT: begin
        // minuend is zero, destination becomes the subtrahend
        a_opnd   = '0;
        b_opnd   = dst_bcd;
        sub_mode = 1'b1;
      end
      default: begin
        sub_mode = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_arith_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic               sub_mode,
  input  logic               c_in,
  output logic [DIGIT_W-1:0] d_out,
  output logic               c_out
);

  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    if (sub_mode) begin
      raw = {1'b0, a_dig} - {1'b0, b_dig} - {{DIGIT_W{1'b0}}, c_in};
      // a negative binary difference means a decimal borrow
      c_out = raw[DIGIT_W];
      fixed = c_out ? (raw - (DIGIT_W+1)'(DIGIT_FIX)) : raw;
    end else begin
      raw = {1'b0, a_dig} + {1'b0, b_dig} + {{DIGIT_W{1'b0}}, c_in};
      c_out = (raw > (DIGIT_W+1)'(DIGIT_MAX));
      fixed = c_out ? (raw + (DIGIT_W+1)'(DIGIT_FIX)) : raw;
    end
    d_out = fixed[DIGIT_W-1:0];
  end

endmodule

// File: rtl/bcd_flag_logic.sv
module bcd_flag_logic
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] result,
  input  logic         carry,
  input  logic         z_in,
  output bcd_flags_t   flags
);

  always_comb begin
    flags.c = carry;
    flags.x = carry;
    flags.z = z_in & ~(|result);
    flags.n = result[W-1];
    flags.v = 1'b0;
  end

endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS  = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] dst_bcd,
  input  logic [W-1:0] src_bcd,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] res_bcd,
  output logic         x_out,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out,
  output logic         v_out
);

  logic [W-1:0]    a_opnd;
  logic [W-1:0]    b_opnd;
  logic            sub_mode;
  logic [DIGITS:0] chain;
  logic [W-1:0]    sum_comb;
  bcd_flags_t      flg_comb;

  bcd_operand_mux #(.DIGITS(DIGITS)) mux_i (
    .op_sel   (op_sel),
    .dst_bcd  (dst_bcd),
    .src_bcd  (src_bcd),
    .a_opnd   (a_opnd),
    .b_opnd   (b_opnd),
    .sub_mode (sub_mode)
  );

  assign chain[0] = x_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_cell cell_i (
      .a_dig    (a_opnd[g*DIGIT_W +: DIGIT_W]),
      .b_dig    (b_opnd[g*DIGIT_W +: DIGIT_W]),
      .sub_mode (sub_mode),
      .c_in     (chain[g]),
      .d_out    (sum_comb[g*DIGIT_W +: DIGIT_W]),
      .c_out    (chain[g+1])
    );
  end

  bcd_flag_logic #(.DIGITS(DIGITS)) flag_i (
    .result (sum_comb),
    .carry  (chain[DIGITS]),
    .z_in   (z_in),
    .flags  (flg_comb)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] res_q;
    bcd_flags_t   flg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q <= '0;
        flg_q <= '0;
      end else begin
        res_q <= sum_comb;
        flg_q <= flg_comb;
      end
    end
    assign res_bcd = res_q;
    assign x_out   = flg_q.x;
    assign c_out   = flg_q.c;
    assign z_out   = flg_q.z;
    assign n_out   = flg_q.n;
    assign v_out   = flg_q.v;
  end else begin : g_comb
    assign res_bcd = sum_comb;
    assign x_out   = flg_comb.x;
    assign c_out   = flg_comb.c;
    assign z_out   = flg_comb.z;
    assign n_out   = flg_comb.n;
    assign v_out   = flg_comb.v;
  end

endmodule

// File: rtl/bcd_arith_chk.sv
module bcd_arith_chk
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS  = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int W = DIGITS * DIGIT_W
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_sel,
  input logic [W-1:0] dst_bcd,
  input logic [W-1:0] src_bcd,
  input logic         x_in,
  input logic         z_in,
  input logic [W-1:0] res_bcd,
  input logic         x_out,
  input logic         c_out,
  input logic         z_out
);

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[i*DIGIT_W +: DIGIT_W] > DIGIT_W'(DIGIT_MAX)) ok = 1'b0;
    end
    return ok;
  endfunction

  // inputs aligned with the outputs they produce
  logic [1:0]   p_op;
  logic [W-1:0] p_dst;
  logic [W-1:0] p_src;
  logic         p_x;
  logic         p_z;

  if (REG_OUT) begin : g_align
    always_ff @(posedge clk) begin
      if (rst) begin
        p_op <= '0; p_dst <= '0; p_src <= '0; p_x <= 1'b0; p_z <= 1'b0;
      end else begin
        p_op <= op_sel; p_dst <= dst_bcd; p_src <= src_bcd;
        p_x <= x_in; p_z <= z_in;
      end
    end

    p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> (res_bcd == '0 && !x_out && !c_out && !z_out));
  end else begin : g_align
    assign p_op  = op_sel;
    assign p_dst = dst_bcd;
    assign p_src = src_bcd;
    assign p_x   = x_in;
    assign p_z   = z_in;
  end

  p_x_tracks_c_r5: assert property (@(posedge clk) disable iff (rst)
    x_out == c_out);

  p_z_never_set_r6: assert property (@(posedge clk) disable iff (rst)
    !p_z |-> !z_out);

  p_z_clear_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (res_bcd != '0) |-> !z_out);

  p_digits_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    (digits_ok(p_dst) && digits_ok(p_src)) |-> digits_ok(res_bcd));

  p_neg_of_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (p_op[1] && p_dst == '0 && !p_x) |-> (res_bcd == '0 && !c_out));

endmodule

bind bcd_arith_unit bcd_arith_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op_sel  (op_sel),
  .dst_bcd (dst_bcd),
  .src_bcd (src_bcd),
  .x_in    (x_in),
  .z_in    (z_in),
  .res_bcd (res_bcd),
  .x_out   (x_out),
  .c_out   (c_out),
  .z_out   (z_out)
);

// File: tb/bcd_arith_unit_tb_top.sv
module bcd_arith_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] dst_bcd = 8'h00;
  logic [7:0] src_bcd = 8'h00;
  logic       x_in = 1'b0;
  logic       z_in = 1'b0;
  logic [7:0] res_bcd;
  logic       x_out, c_out, z_out, n_out, v_out;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bcd_arith_unit #(.DIGITS(2), .REG_OUT(1'b1)) dut_i (
    .clk (clk), .rst (rst), .op_sel (op_sel),
    .dst_bcd (dst_bcd), .src_bcd (src_bcd), .x_in (x_in), .z_in (z_in),
    .res_bcd (res_bcd), .x_out (x_out), .c_out (c_out), .z_out (z_out),
    .n_out (n_out), .v_out (v_out)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // op: 0 add, 1 subtract, 2/3 negate; d,s are decimal values 0..99
  task automatic apply(input logic [1:0] op, input int d, input int s,
                       input logic [7:0] s_raw, input logic xi, input logic zi);
    int t;
    int er;
    logic ec, ez;
    string tag;
    case (op)
      2'd0: begin t = d + s + int'(xi); ec = (t >= 100); er = t % 100; tag = "R1"; end
      2'd1: begin t = d - s - int'(xi); ec = (t < 0); er = (t + 100) % 100; tag = "R2"; end
      default: begin t = 0 - d - int'(xi); ec = (t < 0); er = (t + 100) % 100; tag = "R3"; end
    endcase
    ez = zi && (er == 0);
    op_sel  = op;
    dst_bcd = to_bcd(d);
    src_bcd = s_raw;
    x_in    = xi;
    z_in    = zi;
    @(negedge clk);
    n_vec++;
    if (res_bcd !== to_bcd(er)) begin
      n_bad++;
      $display("FAIL %s op=%0d d=%0d s=%h x=%0b: result %h expected %h",
               tag, op, d, s_raw, xi, res_bcd, to_bcd(er));
    end else if (c_out !== ec) begin
      n_bad++;
      $display("FAIL R4 op=%0d d=%0d s=%h x=%0b: carry %b expected %b",
               op, d, s_raw, xi, c_out, ec);
    end else if (x_out !== ec) begin
      n_bad++;
      $display("FAIL R5 op=%0d d=%0d s=%h: extend %b expected %b",
               op, d, s_raw, x_out, ec);
    end else if (z_out !== ez) begin
      n_bad++;
      $display("FAIL R6 op=%0d d=%0d s=%h z_in=%b: zero %b expected %b",
               op, d, s_raw, zi, z_out, ez);
    end else if (res_bcd[7:4] > 4'd9 || res_bcd[3:0] > 4'd9) begin
      n_bad++;
      $display("FAIL R7 digit out of range: result %h expected digits <= 9", res_bcd);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: ran 200000 cycles expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    // R8: reset state of every output
    if ({res_bcd, x_out, c_out, z_out, n_out, v_out} !== 13'h0) begin
      n_bad++;
      $display("FAIL R8 reset outputs %h expected 0",
               {res_bcd, x_out, c_out, z_out, n_out, v_out});
    end
    rst = 1'b0;

    // R8: one-cycle latency, a directed case: 45 + 38 + 1 = 84
    apply(2'd0, 45, 38, to_bcd(38), 1'b1, 1'b1);
    // R6: zero result keeps z set (50+50 -> 00 carry), and keeps it clear
    apply(2'd0, 50, 50, to_bcd(50), 1'b0, 1'b1);
    apply(2'd0, 50, 50, to_bcd(50), 1'b0, 1'b0);
    // R2/R4: borrow chain 0 - 0 - 1 = 99 with borrow
    apply(2'd1, 0, 0, to_bcd(0), 1'b1, 1'b1);

    // R1, R2, R3 full sweeps with both extend values
    for (int op = 0; op < 3; op++) begin
      for (int xi = 0; xi < 2; xi++) begin
        for (int d = 0; d < 100; d++) begin
          for (int s = 0; s < 100; s++) begin
            logic [7:0] sr;
            // negate gets an arbitrary source byte: it must be ignored (R3)
            sr = (op == 2) ? 8'((s * 37 + d) & 8'hFF) : to_bcd(s);
            apply(2'(op), d, s, sr, 1'(xi), 1'((d + s + xi) & 1));
          end
        end
      end
    end

    // R3: alternate negate code 2'b11
    for (int d = 0; d < 100; d++) begin
      apply(2'd3, d, 0, 8'hA5, 1'(d & 1), 1'b1);
    end

    // R8: synchronous reset clears a nonzero registered result
    apply(2'd0, 12, 34, to_bcd(34), 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (res_bcd !== 8'h00 || c_out !== 1'b0 || z_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 after reset result %h c %b z %b expected 00 0 0",
               res_bcd, c_out, z_out);
    end
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule